// File: doc/BRIEF.md
# Top Swap Reset Vector Remapper

This block sits on the firmware fetch path between the processor and the boot flash. It lets a platform boot from a second copy of its boot block, so that the primary copy can be rewritten without the risk of a machine that no longer starts. The remapping is active while a top-swap control bit is set. It then inverts a single address bit inside the topmost firmware window. The boot-block size field chooses which bit is inverted. As a result, a fetch of the reset vector lands in the copy just below the primary boot block.

Three registers configure the block through a simple write/read port.

- **Backed-up control register.** Holds the top-swap bit. The bit survives a warm reset and clears only on a cold reset.
- **General control register.** Holds the boot-block size field and an interface lockdown bit. Once the lockdown bit is set, it freezes both the top-swap bit and the size field until the next reset.
- **Firmware control register.** Mirrors the top-swap state as a read-only status bit.

The address translation is purely combinational. Register reads return one cycle after the request.

Top module: `tsw_remap`

## Requirements
- R1: After a cold reset every register reads as zero and every fetch address passes through unchanged.
- R2: While the top-swap bit (backed-up control register, address 0, bit 0) is clear, `fw_addr_out` equals `fw_addr_in` for every address.
- R3: With top swap set and size code 0 (64 KB), bit 16 is inverted; the reset vector fetch 0xFFFFFFF0 becomes 0xFFFEFFF0.
- R4: The size field (general control register, address 1, bits 12:10) selects the inverted bit: codes 0, 1, 2, 3, 4 select bits 16, 17, 18, 19, 20; codes 5 to 7 behave as code 4. No other bit ever changes.
- R5: Only addresses whose bits 31:21 are all ones are translated; any other address passes through unchanged even with top swap set.
- R6: The lockdown bit (address 1, bit 0) is set by writing 1 and cannot be cleared by a write. While it is set, writes to the top-swap bit and to the size field are ignored.
- R7: Bit 4 of the firmware control register (address 2) reads as the current top-swap bit, and writes to that register have no effect.
- R8: A warm reset clears the lockdown bit, the size field and the read data, but keeps the top-swap bit. A cold reset clears all of them. Either reset takes priority over a write in the same cycle.
- R9: `reg_rdata` presents the register selected by `reg_addr` in the cycle after `reg_re` is high and holds until the next read or reset. Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| cold_rst | input | 1 | Synchronous active-high cold reset, clears all state |
| warm_rst | input | 1 | Synchronous active-high warm reset, keeps the top-swap bit |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 backed-up control, 1 general control, 2 firmware control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| fw_addr_in | input | 32 | Fetch address from the processor |
| fw_addr_out | output | 32 | Translated fetch address toward the flash |
| ts_status | output | 1 | Current top-swap state |

## Verification
A wrong top-swap or size state shows up at `fw_addr_out` in the same cycle in which an address inside the top window is presented. The error appears as a flip of the wrong bit, a missing flip, or a flip outside the window. Lockdown or warm-reset faults stay invisible until a later write is wrongly accepted or refused. They are exposed by reading the registers back the next cycle and by the changed translation that follows. The reference model is therefore compared on the address path every cycle. It is also compared on the read path after each register access.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  localparam int ADDR_W    = 32;
  localparam int DATA_W    = 32;
  localparam int SIZE_W    = 3;
  localparam int RSEL_W    = 2;
  localparam int BASE_BIT  = 16;
  localparam int NUM_SIZES = 5;
  localparam int WIN_LSB   = BASE_BIT + NUM_SIZES;

  localparam logic [RSEL_W-1:0] REG_CTRL = 2'd0;
  localparam logic [RSEL_W-1:0] REG_GEN  = 2'd1;
  localparam logic [RSEL_W-1:0] REG_FWC  = 2'd2;

  localparam int TS_BIT   = 0;
  localparam int LOCK_BIT = 0;
  localparam int SIZE_LSB = 10;
  localparam int STAT_BIT = 4;
endpackage

// File: rtl/tsw_regs.sv
module tsw_regs
  import tsw_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int SW = SIZE_W,
  parameter int AW = RSEL_W
) (
  input  logic          clk,
  input  logic          cold_rst,
  input  logic          warm_rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  output logic          ts_q,
  output logic          lock_q,
  output logic [SW-1:0] size_q
);
  logic wr_ctrl, wr_gen;
  assign wr_ctrl = we && (waddr == REG_CTRL);
  assign wr_gen  = we && (waddr == REG_GEN);

  always_ff @(posedge clk) begin
    if (cold_rst) begin
      ts_q <= 1'b0;
    end else if (!warm_rst && wr_ctrl && !lock_q) begin
      ts_q <= wdata[TS_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (cold_rst || warm_rst) begin
      lock_q <= 1'b0;
      size_q <= '0;
    end else if (wr_gen) begin
      if (wdata[LOCK_BIT]) lock_q <= 1'b1;
      if (!lock_q) size_q <= wdata[SIZE_LSB +: SW];
    end
  end

  // R6
  lock_sticky_chk: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
    lock_q |=> lock_q);
  // R6
  ts_frozen_chk: assert property (@(posedge clk) disable iff (cold_rst)
    lock_q |=> $stable(ts_q));
  // R6
  size_frozen_chk: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
    lock_q |=> $stable(size_q));
  // R8
  ts_warm_keep_chk: assert property (@(posedge clk) disable iff (cold_rst)
    warm_rst |=> $stable(ts_q));
endmodule

// File: rtl/tsw_flipmask.sv
module tsw_flipmask
  import tsw_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int SW    = SIZE_W,
  parameter int BASE  = BASE_BIT,
  parameter int NSIZE = NUM_SIZES
) (
  input  logic [SW-1:0] size,
  output logic [AW-1:0] mask
);
  localparam logic [SW-1:0] MAX_CODE = SW'(NSIZE - 1);
  logic [SW-1:0] sel;
  assign sel = (size > MAX_CODE) ? MAX_CODE : size;

  for (genvar b = 0; b < AW; b++) begin : g_bit
    if (b >= BASE && b < BASE + NSIZE) begin : g_sel
      assign mask[b] = (sel == SW'(b - BASE));
    end else begin : g_zero
      assign mask[b] = 1'b0;
    end
  end
endmodule

// File: rtl/tsw_xlate.sv
module tsw_xlate
  import tsw_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int WLSB = WIN_LSB
) (
  input  logic          ts_en,
  input  logic [AW-1:0] mask,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out
);
  logic in_window;
  assign in_window = &addr_in[AW-1:WLSB];
  assign addr_out  = (ts_en && in_window) ? (addr_in ^ mask) : addr_in;
endmodule

// File: rtl/tsw_rdport.sv
module tsw_rdport
  import tsw_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int SW = SIZE_W,
  parameter int AW = RSEL_W
) (
  input  logic          clk,
  input  logic          cold_rst,
  input  logic          warm_rst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  input  logic          ts_q,
  input  logic          lock_q,
  input  logic [SW-1:0] size_q,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    case (raddr)
      REG_CTRL: rd_next[TS_BIT] = ts_q;
      REG_GEN: begin
        rd_next[LOCK_BIT]          = lock_q;
        rd_next[SIZE_LSB +: SW]    = size_q;
      end
      REG_FWC:  rd_next[STAT_BIT] = ts_q;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (cold_rst || warm_rst) rdata <= '0;
    else if (re)              rdata <= rd_next;
  end

  // R7
  status_mirror_chk: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
    (re && raddr == REG_FWC) |=> (rdata[STAT_BIT] == $past(ts_q)));
  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
    !re |=> $stable(rdata));
endmodule

// File: rtl/tsw_remap.sv
module tsw_remap
  import tsw_pkg::*;
(
  input  logic                clk,
  input  logic                cold_rst,
  input  logic                warm_rst,
  input  logic                reg_we,
  input  logic                reg_re,
  input  logic [RSEL_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [ADDR_W-1:0]   fw_addr_in,
  output logic [ADDR_W-1:0]   fw_addr_out,
  output logic                ts_status
);
  logic              ts_q;
  logic              lock_q;
  logic [SIZE_W-1:0] size_q;
  logic [ADDR_W-1:0] flip_mask;

  tsw_regs u_regs (
    .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst),
    .we(reg_we), .waddr(reg_addr), .wdata(reg_wdata),
    .ts_q(ts_q), .lock_q(lock_q), .size_q(size_q)
  );

  tsw_flipmask u_mask (.size(size_q), .mask(flip_mask));

  tsw_xlate u_xlate (
    .ts_en(ts_q), .mask(flip_mask),
    .addr_in(fw_addr_in), .addr_out(fw_addr_out)
  );

  tsw_rdport u_rd (
    .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst),
    .re(reg_re), .raddr(reg_addr),
    .ts_q(ts_q), .lock_q(lock_q), .size_q(size_q),
    .rdata(reg_rdata)
  );

  assign ts_status = ts_q;

  // R2
  disabled_pass_chk: assert property (@(posedge clk) disable iff (cold_rst)
    !ts_status |-> (fw_addr_out == fw_addr_in));
  // R5
  outside_pass_chk: assert property (@(posedge clk) disable iff (cold_rst)
    !(&fw_addr_in[ADDR_W-1:WIN_LSB]) |-> (fw_addr_out == fw_addr_in));
  // R4
  single_flip_chk: assert property (@(posedge clk) disable iff (cold_rst)
    $countones(fw_addr_out ^ fw_addr_in) <= 1);
  // R4
  flip_range_chk: assert property (@(posedge clk) disable iff (cold_rst)
    ((fw_addr_out ^ fw_addr_in) & ~(ADDR_W'({NUM_SIZES{1'b1}}) << BASE_BIT)) == '0);
endmodule

// File: tb/tsw_remap_tb.sv
`timescale 1ns/1ps
module tsw_remap_tb;
  logic        clk = 1'b0;
  logic        cold_rst = 1'b1, warm_rst = 1'b0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic [31:0] fw_addr_in = 32'd0;
  logic [31:0] fw_addr_out;
  logic        ts_status;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tsw_remap u_dut (.*);

  // reference model state
  bit       m_ts, m_lock;
  int       m_size;
  bit [31:0] m_rd;

  always @(posedge clk) begin
    if (cold_rst) begin
      m_ts <= 0; m_lock <= 0; m_size <= 0; m_rd <= 0;
    end else if (warm_rst) begin
      m_lock <= 0; m_size <= 0; m_rd <= 0;
    end else begin
      if (reg_we && reg_addr == 0 && !m_lock) m_ts <= reg_wdata[0];
      if (reg_we && reg_addr == 1) begin
        if (reg_wdata[0]) m_lock <= 1;
        if (!m_lock) m_size <= int'(reg_wdata[12:10]);
      end
      if (reg_re) begin
        case (reg_addr)
          2'd0: m_rd <= {31'd0, m_ts};
          2'd1: m_rd <= (32'(m_size) << 10) | {31'd0, m_lock};
          2'd2: m_rd <= {27'd0, m_ts, 4'd0};
          default: m_rd <= 32'd0;
        endcase
      end
    end
  end

  function automatic bit [31:0] exp_addr(bit [31:0] a);
    int k;
    bit [31:0] r = a;
    k = (m_size > 4) ? 4 : m_size;
    if (m_ts && (&a[31:21])) r[16 + k] = ~r[16 + k];
    return r;
  endfunction

  task automatic chk(bit [31:0] act, bit [31:0] expv, string tag);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // address stimulus: pattern sweep unless a task forces a value
  bit        force_en = 0;
  bit [31:0] force_val = 0;
  int        pidx = 0;
  always @(posedge clk) begin
    #1;
    if (force_en) fw_addr_in = force_val;
    else begin
      case (pidx % 6)
        0: fw_addr_in = 32'hFFFFFFF0;
        1: fw_addr_in = 32'hFFE00000;
        2: fw_addr_in = 32'hFFDFFFF0;
        3: fw_addr_in = 32'h000FFFF0;
        4: fw_addr_in = 32'hFFF5A5A5;
        default: fw_addr_in = $urandom;
      endcase
      pidx++;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!cold_rst && !done) begin
      string tag;
      if (!m_ts) tag = "R2";
      else if (!(&fw_addr_in[31:21])) tag = "R5";
      else tag = "R4";
      chk(fw_addr_out, exp_addr(fw_addr_in), tag);
      chk(reg_rdata, m_rd, "R9");
      chk({31'd0, ts_status}, {31'd0, m_ts}, "R7");
    end
  end

  task automatic wr(bit [1:0] a, bit [31:0] d);
    @(posedge clk); #1;
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 0;
  endtask

  task automatic rd_chk(bit [1:0] a, bit [31:0] expv, string tag);
    @(posedge clk); #1;
    reg_re = 1; reg_addr = a;
    @(posedge clk); #1;
    reg_re = 0;
    @(negedge clk);
    chk(reg_rdata, expv, tag);
  endtask

  task automatic addr_chk(bit [31:0] a, bit [31:0] expv, string tag);
    force_en = 1; force_val = a;
    @(posedge clk); @(negedge clk);
    chk(fw_addr_out, expv, tag);
    force_en = 0;
  endtask

  task automatic pulse(bit cold);
    @(posedge clk); #1;
    if (cold) cold_rst = 1; else warm_rst = 1;
    @(posedge clk); #1;
    cold_rst = 0; warm_rst = 0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 cold_rst = 0;
    // R1 reset state
    rd_chk(2'd0, 32'd0, "R1");
    rd_chk(2'd1, 32'd0, "R1");
    rd_chk(2'd2, 32'd0, "R1");
    addr_chk(32'hFFFFFFF0, 32'hFFFFFFF0, "R1");
    // R2 disabled pass-through
    repeat (12) @(posedge clk);
    // R3 top swap with 64 KB boot block
    wr(2'd0, 32'd1);
    addr_chk(32'hFFFFFFF0, 32'hFFFEFFF0, "R3");
    // R5 outside window
    addr_chk(32'hFFDFFFF0, 32'hFFDFFFF0, "R5");
    addr_chk(32'h7FFFFFF0, 32'h7FFFFFF0, "R5");
    // R4 every size code
    for (int s = 0; s < 8; s++) begin
      wr(2'd1, 32'(s) << 10);
      rd_chk(2'd1, 32'(s) << 10, "R4");
      addr_chk(32'hFFFFFFF0, 32'hFFFFFFF0 ^ (32'h1 << (16 + ((s > 4) ? 4 : s))), "R4");
      repeat (6) @(posedge clk);
    end
    // R7 status mirror and ignored write
    rd_chk(2'd2, 32'h10, "R7");
    wr(2'd2, 32'h0);
    rd_chk(2'd2, 32'h10, "R7");
    addr_chk(32'hFFFFFFF0, 32'hFFEFFFF0, "R7");
    // R6 lockdown
    wr(2'd1, (32'd2 << 10) | 32'd1);
    rd_chk(2'd1, (32'd2 << 10) | 32'd1, "R6");
    wr(2'd0, 32'd0);
    rd_chk(2'd0, 32'd1, "R6");
    wr(2'd1, 32'd5 << 10);
    rd_chk(2'd1, (32'd2 << 10) | 32'd1, "R6");
    addr_chk(32'hFFFFFFF0, 32'hFFFBFFF0, "R6");
    repeat (6) @(posedge clk);
    // R8 warm reset keeps top swap
    pulse(0);
    rd_chk(2'd1, 32'd0, "R8");
    rd_chk(2'd0, 32'd1, "R8");
    addr_chk(32'hFFFFFFF0, 32'hFFFEFFF0, "R8");
    wr(2'd1, 32'd3 << 10);
    addr_chk(32'hFFFFFFF0, 32'hFFF7FFF0, "R8");
    // R8 cold reset clears everything
    pulse(1);
    rd_chk(2'd0, 32'd0, "R8");
    rd_chk(2'd1, 32'd0, "R8");
    addr_chk(32'hFFFFFFF0, 32'hFFFFFFF0, "R8");
    // R9 unused address reads zero
    wr(2'd0, 32'd1);
    rd_chk(2'd3, 32'd0, "R9");
    repeat (10) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule